// File: doc/BRIEF.md
# Byte-Port External Memory Access Unit

This block sits on the I/O bus of a small 8-bit controller and lets firmware reach a 16-bit-wide external memory addressed by 24-bit word addresses. The firmware writes the word address one byte at a time to three address ports. For a store it also writes the two bytes of write data. It then writes a command byte that starts a store or a load. The arbiter side of the block raises a request and holds it until the memory reports that the operation has begun. For a load, the block then waits for the returned word and captures it. The firmware polls a status byte for a store in flight, a load in flight, and captured load data. It then reads the captured word back through two byte ports.

Only the low four bits of the controller's port number reach the block. Bit 3 must be low for the block to respond. Address and data are copied into request registers when a command is accepted. Later port writes therefore cannot disturb an operation already in flight.

A control state machine has four states. `ST_IDLE` takes `go_store` to `ST_WR_WAIT` when an accepted command has the store bit set. It takes `go_load` to `ST_RD_WAIT` when the command has only the load bit set. `ST_WR_WAIT` takes `store_begun` back to `ST_IDLE` on `mem_ack`. `ST_RD_WAIT` takes `load_begun` to `ST_RD_DATA` on `mem_ack`. `ST_RD_DATA` takes `load_done` back to `ST_IDLE` on `mem_rvalid`, which also captures `mem_rdata`.

Top module: `pmem_port_if`

## Requirements
- R1: Writes to ports 0, 1 and 2 set address bits 7:0, 15:8 and 23:16. The full 24-bit value appears on `mem_addr` for the next accepted command.
- R2: Writes to ports 4 and 5 set write-data bits 7:0 and 15:8. These appear on `mem_wdata` for the next accepted store.
- R3: A command byte (port 7) with bit 1 set starts a store. From the next cycle, `mem_req` and `mem_we` stay high until `mem_ack`. While the store is in flight, status bit 2 reads 1.
- R4: A command byte with bit 0 set and bit 1 clear starts a load. `mem_req` stays high with `mem_we` low until `mem_ack`. Status bit 1 reads 1 from acceptance until the load data is captured.
- R5: While waiting for load data, `mem_rvalid` captures `mem_rdata`. Bits 7:0 then read at input port 4 and bits 15:8 at input port 5, and status bit 0 is set.
- R6: Writing any address port clears status bit 0. This takes precedence over a capture in the same cycle. Accepting a load also clears status bit 0.
- R7: A command byte written while a store or load is in flight is ignored.
- R8: A command byte with both bits set performs only a store. A command byte with neither bit set does nothing.
- R9: When port-number bit 3 is 1, a port write changes no register and starts no operation.
- R10: `in_port` is 0 when `read_strobe` is low, when port-number bit 3 is 1, and for unmapped input ports. The status byte at port 7 carries zeros above bit 2.
- R11: After reset the block is idle. `mem_req` is low, and status and captured data read as 0.
- R12: Port writes made while an operation is in flight leave `mem_addr`, `mem_wdata` and `mem_we` unchanged until a later command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 4 | Low four bits of the controller port number |
| write_strobe | input | 1 | Controller output-port write strobe |
| read_strobe | input | 1 | Controller input-port read strobe |
| out_port | input | 8 | Byte written by the controller |
| in_port | output | 8 | Byte returned to the controller |
| mem_req | output | 1 | Request to the memory arbiter |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | 24 | Word address of the request |
| mem_wdata | output | 16 | Store data |
| mem_ack | input | 1 | Memory has begun the requested operation |
| mem_rvalid | input | 1 | Load data valid on `mem_rdata` |
| mem_rdata | input | 16 | Load data from memory |

## Verification
Two events can fall in the same cycle: the returned load word being captured, and the firmware rewriting an address byte. The bench provokes this by replacing the memory model with hand-driven acknowledge and data-valid pulses. It asserts `mem_rvalid` on the same clock edge as an address-port write strobe. The result passes only if the load-pending flag has cleared, the captured word still reads back at ports 4 and 5, and the read-done flag reads 0. The same hand-driven mode holds a store request open while the address and data ports are rewritten. This shows that the memory-side buses stay frozen.

// File: rtl/pmi_pkg.sv
package pmi_pkg;

    localparam int BYTE_W = 8;

    // Port numbers (low three bits; bit 3 selects this block when low)
    localparam logic [2:0] PORT_ADDR_BASE = 3'd0;
    localparam logic [2:0] PORT_DATA_BASE = 3'd4;
    localparam logic [2:0] PORT_CMD       = 3'd7;

    // Command byte bits
    localparam int CMD_STORE_BIT = 1;
    localparam int CMD_LOAD_BIT  = 0;

    // Status byte bits
    localparam int STAT_WRX_BIT = 2;
    localparam int STAT_RDX_BIT = 1;
    localparam int STAT_RDD_BIT = 0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_WAIT = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_RD_DATA = 2'd3
    } pmi_state_t;

endpackage

// File: rtl/pmi_port_regs.sv
module pmi_port_regs
    import pmi_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              addr_touch
);

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;

    logic [ADDR_BYTES-1:0] addr_hit;

    genvar gi;
    generate
        for (gi = 0; gi < ADDR_BYTES; gi++) begin : g_addr
            assign addr_hit[gi] = wr_en && (wr_idx == PORT_ADDR_BASE + 3'(gi));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q[gi*BYTE_W +: BYTE_W] <= '0;
                end else if (addr_hit[gi]) begin
                    addr_q[gi*BYTE_W +: BYTE_W] <= wr_byte;
                end
            end
        end

        for (gi = 0; gi < DATA_BYTES; gi++) begin : g_data
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wdata_q[gi*BYTE_W +: BYTE_W] <= '0;
                end else if (wr_en && (wr_idx == PORT_DATA_BASE + 3'(gi))) begin
                    wdata_q[gi*BYTE_W +: BYTE_W] <= wr_byte;
                end
            end
        end
    endgenerate

    assign addr_touch = |addr_hit;

endmodule

// File: rtl/pmi_ctrl_fsm.sv
module pmi_ctrl_fsm
    import pmi_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_store,
    input  logic              cmd_load,
    input  logic              addr_touch,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic              wrx,
    output logic              rdx,
    output logic              rdd
);

    pmi_state_t state, state_nx;
    logic       go_store, go_load, capture;

    // Command acceptance: only in idle; store has priority over load
    assign go_store = cmd_wr && (state == ST_IDLE) && cmd_store;
    assign go_load  = cmd_wr && (state == ST_IDLE) && !cmd_store && cmd_load;
    assign capture  = (state == ST_RD_DATA) && mem_rvalid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go_store) begin
                    state_nx = ST_WR_WAIT;
                end else if (go_load) begin
                    state_nx = ST_RD_WAIT;
                end
            end
            ST_WR_WAIT: if (mem_ack)    state_nx = ST_IDLE;
            ST_RD_WAIT: if (mem_ack)    state_nx = ST_RD_DATA;
            ST_RD_DATA: if (mem_rvalid) state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        wrx     = 1'b0;
        rdx     = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_WR_WAIT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                wrx     = 1'b1;
            end
            ST_RD_WAIT: begin
                mem_req = 1'b1;
                rdx     = 1'b1;
            end
            ST_RD_DATA: begin
                rdx     = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // Request snapshot taken on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (go_store || go_load) begin
            mem_addr  <= addr_q;
            mem_wdata <= wdata_q;
        end
    end

    // Load data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= mem_rdata;
        end
    end

    // Read-done flag: address rewrite wins over capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdd <= 1'b0;
        end else if (addr_touch) begin
            rdd <= 1'b0;
        end else if (capture) begin
            rdd <= 1'b1;
        end else if (go_load) begin
            rdd <= 1'b0;
        end
    end

endmodule

// File: rtl/pmi_rd_mux.sv
module pmi_rd_mux
    import pmi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              read_strobe,
    input  logic [3:0]        port_sel,
    input  logic [DATA_W-1:0] rdata_q,
    input  logic              wrx,
    input  logic              rdx,
    input  logic              rdd,
    output logic [BYTE_W-1:0] in_port
);

    localparam int DATA_BYTES = DATA_W / BYTE_W;

    logic [BYTE_W-1:0] status_byte;

    always_comb begin
        status_byte = '0;
        status_byte[STAT_WRX_BIT] = wrx;
        status_byte[STAT_RDX_BIT] = rdx;
        status_byte[STAT_RDD_BIT] = rdd;
    end

    always_comb begin
        in_port = '0;
        if (read_strobe && !port_sel[3]) begin
            if (port_sel[2:0] == PORT_CMD) begin
                in_port = status_byte;
            end
            for (int b = 0; b < DATA_BYTES; b++) begin
                if (port_sel[2:0] == PORT_DATA_BASE + 3'(b)) begin
                    in_port = rdata_q[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/pmem_port_if.sv
module pmem_port_if
    import pmi_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        port_sel,
    input  logic              write_strobe,
    input  logic              read_strobe,
    input  logic [7:0]        out_port,
    output logic [7:0]        in_port,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              wr_en;
    logic              cmd_wr;
    logic              addr_touch;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wrx, rdx, rdd;

    assign wr_en  = write_strobe && !port_sel[3];
    assign cmd_wr = wr_en && (port_sel[2:0] == PORT_CMD);

    pmi_port_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (port_sel[2:0]),
        .wr_byte    (out_port),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .addr_touch (addr_touch)
    );

    pmi_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_store  (out_port[CMD_STORE_BIT]),
        .cmd_load   (out_port[CMD_LOAD_BIT]),
        .addr_touch (addr_touch),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .mem_ack    (mem_ack),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rdata_q    (rdata_q),
        .wrx        (wrx),
        .rdx        (rdx),
        .rdd        (rdd)
    );

    pmi_rd_mux #(.DATA_W(DATA_W)) u_rdmux (
        .read_strobe (read_strobe),
        .port_sel    (port_sel),
        .rdata_q     (rdata_q),
        .wrx         (wrx),
        .rdx         (rdx),
        .rdd         (rdd),
        .in_port     (in_port)
    );

endmodule

// File: rtl/pmem_port_if_chk.sv
module pmem_port_if_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        port_sel,
    input logic              write_strobe,
    input logic              read_strobe,
    input logic [7:0]        in_port,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              wrx,
    input logic              rdd
);

    // R3 R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // R12
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

    // R6
    rdd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (write_strobe && !port_sel[3] && (port_sel[2:0] < 3'd3)) |=> !rdd);

    // R10
    in_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !read_strobe |-> (in_port == 8'h00));

    // R3
    wrx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrx |-> (mem_req && mem_we));

    // R9
    foreign_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (write_strobe && port_sel[3] && !mem_req) |=> !mem_req);

endmodule

bind pmem_port_if pmem_port_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_sel     (port_sel),
    .write_strobe (write_strobe),
    .read_strobe  (read_strobe),
    .in_port      (in_port),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .wrx          (wrx),
    .rdd          (rdd)
);

// File: tb/pmem_port_if_bench.sv
module pmem_port_if_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  port_sel = '0;
    logic        write_strobe = 1'b0;
    logic        read_strobe = 1'b0;
    logic [7:0]  out_port = '0;
    logic [7:0]  in_port;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    int n_checks = 0;
    int n_err = 0;
    bit auto_mem = 1'b1;
    bit finished = 1'b0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [23:0] last_waddr = '0;
    logic [15:0] last_wdata = '0;

    always #4 clk = ~clk;

    pmem_port_if u_pmem_port_if (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel),
        .write_strobe(write_strobe), .read_strobe(read_strobe),
        .out_port(out_port), .in_port(in_port),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] exp_rdata(input logic [23:0] a);
        return {a[15:8] ^ 8'hC3, a[7:0] ^ a[23:16]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [3:0] p, input logic [7:0] v);
        @(negedge clk);
        port_sel = p; out_port = v; write_strobe = 1'b1;
        @(negedge clk);
        write_strobe = 1'b0;
    endtask

    task automatic io_read(input logic [3:0] p, output logic [7:0] v);
        @(negedge clk);
        port_sel = p; read_strobe = 1'b1;
        #1 v = in_port;
        #1 read_strobe = 1'b0;
    endtask

    task automatic load_addr(input logic [23:0] a);
        io_write(4'd0, a[7:0]);
        io_write(4'd1, a[15:8]);
        io_write(4'd2, a[23:16]);
    endtask

    task automatic load_data(input logic [15:0] d);
        io_write(4'd4, d[7:0]);
        io_write(4'd5, d[15:8]);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        bit done = 1'b0;
        for (int i = 0; i < 60 && !done; i++) begin
            io_read(4'd7, s);
            if ((s & 8'h06) == 8'h00) done = 1'b1;
        end
        check(req, 32'(done), 32'd1);
    endtask

    task automatic print_summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // Memory model
    initial begin
        forever begin
            @(negedge clk);
            if (auto_mem && mem_req) begin
                logic        we_s;
                logic [23:0] a_s;
                logic [15:0] d_s;
                repeat ($urandom_range(2, 5)) @(negedge clk);
                we_s = mem_we; a_s = mem_addr; d_s = mem_wdata;
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                if (we_s) begin
                    wr_cnt++; last_waddr = a_s; last_wdata = d_s;
                end else begin
                    rd_cnt++;
                    repeat ($urandom_range(1, 4)) @(negedge clk);
                    mem_rdata = exp_rdata(a_s);
                    mem_rvalid = 1'b1;
                    @(negedge clk);
                    mem_rvalid = 1'b0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            print_summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  s;
        logic [7:0]  b0, b1;
        logic [23:0] a;
        logic [15:0] d;
        int          w0, r0;
        int          seed_v;
        seed_v = $urandom(32'h1F2E);

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        io_read(4'd7, s); check("R11 status", 32'(s), 32'h0);
        io_read(4'd4, s); check("R11 rdata lo", 32'(s), 32'h0);
        io_read(4'd5, s); check("R11 rdata hi", 32'(s), 32'h0);
        check("R11 mem_req", 32'(mem_req), 32'h0);

        // R10 unmapped and foreign input ports
        io_read(4'd3, s);  check("R10 unmapped port", 32'(s), 32'h0);
        io_read(4'hF, s);  check("R10 bit3 port", 32'(s), 32'h0);

        // R3 directed store
        load_addr(24'h123456); load_data(16'hBEEF);
        io_write(4'd7, 8'h02);
        io_read(4'd7, s); check("R3 WRX pending", 32'(s), 32'h04);
        wait_idle("R3 store completes");
        check("R1 store addr", 32'(last_waddr), 32'h123456);
        check("R2 store data", 32'(last_wdata), 32'hBEEF);

        // R4/R5 directed load
        load_addr(24'hA50F3C);
        io_write(4'd7, 8'h01);
        io_read(4'd7, s); check("R4 RDX pending", 32'(s), 32'h02);
        wait_idle("R4 load completes");
        io_read(4'd7, s); check("R5 RDD set", 32'(s), 32'h01);
        io_read(4'd4, b0); io_read(4'd5, b1);
        check("R5 load data", 32'({b1, b0}), 32'(exp_rdata(24'hA50F3C)));

        // R6 address rewrite clears RDD
        io_write(4'd1, 8'h0F);
        io_read(4'd7, s); check("R6 addr write clears RDD", 32'(s), 32'h00);

        // R6 load acceptance clears RDD
        io_write(4'd7, 8'h01); wait_idle("R6 load");
        io_read(4'd7, s); check("R6 RDD before new load", 32'(s), 32'h01);
        io_write(4'd7, 8'h01);
        io_read(4'd7, s); check("R6 new load clears RDD", 32'(s), 32'h02);
        wait_idle("R6 second load");

        // R7 command while busy ignored
        w0 = wr_cnt; r0 = rd_cnt;
        load_addr(24'h00ABCD);
        io_write(4'd7, 8'h02);
        io_write(4'd7, 8'h01);
        wait_idle("R7 busy");
        repeat (10) @(negedge clk);
        check("R7 one store", 32'(wr_cnt - w0), 32'd1);
        check("R7 no load", 32'(rd_cnt - r0), 32'd0);

        // R8 both bits -> store only; zero command -> nothing
        w0 = wr_cnt; r0 = rd_cnt;
        io_write(4'd7, 8'h03); wait_idle("R8 both");
        repeat (4) @(negedge clk);
        check("R8 both bits store", 32'(wr_cnt - w0), 32'd1);
        check("R8 both bits no load", 32'(rd_cnt - r0), 32'd0);
        io_write(4'd7, 8'h00);
        repeat (3) @(negedge clk);
        check("R8 zero command", 32'(mem_req), 32'h0);

        // R9 bit3 set ports ignored
        w0 = wr_cnt; r0 = rd_cnt;
        load_addr(24'h445566);
        io_write(4'hF, 8'h02);
        io_write(4'h8, 8'h77);
        repeat (3) @(negedge clk);
        check("R9 no request", 32'(mem_req), 32'h0);
        io_write(4'd7, 8'h02); wait_idle("R9 store");
        check("R9 addr byte kept", 32'(last_waddr), 32'h445566);

        // R12 port writes during pending op
        repeat (4) @(negedge clk);
        auto_mem = 1'b0;
        load_addr(24'h010203); load_data(16'h1111);
        io_write(4'd7, 8'h02);
        load_addr(24'hFFFFFF); load_data(16'h2222);
        check("R12 req held", 32'(mem_req), 32'h1);
        check("R12 addr frozen", 32'(mem_addr), 32'h010203);
        check("R12 data frozen", 32'(mem_wdata), 32'h1111);
        @(negedge clk) mem_ack = 1'b1;
        @(negedge clk) mem_ack = 1'b0;
        auto_mem = 1'b1;
        io_write(4'd7, 8'h02); wait_idle("R12 next store");
        check("R12 new addr used", 32'(last_waddr), 32'hFFFFFF);
        check("R12 new data used", 32'(last_wdata), 32'h2222);

        // R6 capture and address write in the same cycle
        repeat (4) @(negedge clk);
        auto_mem = 1'b0;
        load_addr(24'h000777);
        io_write(4'd7, 8'h01);
        @(negedge clk) mem_ack = 1'b1;
        @(negedge clk) begin
            mem_ack = 1'b0;
        end
        @(negedge clk) begin
            mem_rdata = 16'h5AC3; mem_rvalid = 1'b1;
            port_sel = 4'd0; out_port = 8'h99; write_strobe = 1'b1;
        end
        @(negedge clk) begin
            mem_rvalid = 1'b0; write_strobe = 1'b0;
        end
        io_read(4'd7, s); check("R6 clear wins over capture", 32'(s), 32'h00);
        io_read(4'd4, b0); io_read(4'd5, b1);
        check("R5 data captured in race", 32'({b1, b0}), 32'h5AC3);
        auto_mem = 1'b1;

        // Random traffic
        for (int it = 0; it < 60; it++) begin
            a = 24'($urandom);
            load_addr(a);
            if ($urandom_range(0, 1) == 1) begin
                d = 16'($urandom);
                load_data(d);
                io_write(4'd7, 8'h02);
                wait_idle("R3 random store");
                check("R1 random store addr", 32'(last_waddr), 32'(a));
                check("R2 random store data", 32'(last_wdata), 32'(d));
            end else begin
                io_write(4'd7, 8'h01);
                wait_idle("R4 random load");
                io_read(4'd7, s); check("R5 random RDD", 32'(s), 32'h01);
                io_read(4'd4, b0); io_read(4'd5, b1);
                check("R1 random load data", 32'({b1, b0}), 32'(exp_rdata(a)));
            end
            repeat (6) @(negedge clk);
        end

        finished = 1'b1;
        print_summary();
        $finish;
    end

endmodule